// File: doc/BRIEF.md
# UART Receive Line Status Logic

This block builds the 8-bit line status word of a UART whose receive side holds up to sixteen characters in a FIFO. Every stored character carries its own error tags (parity, framing, break). A tag is reported only once its character has moved to the head of the FIFO. A separate summary bit stays high for as long as any tagged character is still queued. The block also detects overruns, passes through the transmitter's empty indications, and admits only one break character per break condition on the line.

The serial receiver presents each finished character for one cycle, together with its tags. The transmitter supplies two levels: transmit FIFO empty and shift register empty. The CPU side gives a one-cycle strobe for a status read and another for a data read. A data read pops the head character, and the head character is always visible on the data output.

Top module: `uart_lsr_core`

## Requirements
- R1: Status bit 0 is 1 whenever the receive FIFO holds at least one character. After a character is accepted into an empty FIFO, bit 0 reads 1 from the cycle after `rx_done`. It returns to 0 the cycle after the last character is popped.
- R2: A data read (`rbr_rd`) on a non-empty FIFO removes the head character. `rbr_data` shows the head character, and characters leave in the order they arrived. The FIFO holds DEPTH characters, 16 by default.
- R3: If a character completes while the FIFO already holds DEPTH characters, that character is discarded, the stored characters are left unchanged, and bit 1 reads 1 from the next cycle.
- R4: Bit 1 is sticky and is cleared by a status read (`lsr_rd`). If a new overrun occurs in the same cycle as the read, bit 1 stays set.
- R5: Bit 2 (parity) and bit 3 (framing) are loaded from the tags of a character at the moment it becomes the head of the FIFO. This happens on a push into an empty FIFO or on a pop that exposes a new head. The bits are sticky and are cleared by a status read. A capture in the same cycle as the read takes precedence.
- R6: Bit 4 (break) is loaded from the head character's break tag in the same way as R5. While a break condition lasts, only the first break character is stored. Further characters reported with `rx_brk` are dropped and do not count as overruns. The condition ends with the first completed character that has `rx_brk` low.
- R7: Bit 7 is 1 while at least one queued character carries any tag, and 0 once none remain.
- R8: Bit 5 equals `tx_fifo_empty`.
- R9: Bit 6 is 1 only when both `tx_fifo_empty` and `tx_shift_empty` are 1.
- R10: After reset the FIFO is empty, no break condition is active, and bits 0 to 4 and bit 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_done | input | 1 | One-cycle strobe: a received character is complete |
| rx_data | input | 8 | Received character |
| rx_par_err | input | 1 | Parity error tag for the character |
| rx_frm_err | input | 1 | Framing error tag for the character |
| rx_brk | input | 1 | The character is a break (line low for a full frame) |
| tx_fifo_empty | input | 1 | Transmit FIFO is empty |
| tx_shift_empty | input | 1 | Transmit shift register is empty |
| lsr_rd | input | 1 | CPU reads the status word this cycle |
| rbr_rd | input | 1 | CPU reads the receive data this cycle |
| rbr_data | output | 8 | Character at the FIFO head |
| lsr | output | 8 | Line status word |

## Verification
The stimulus mixes several kinds of traffic. Fill-heavy bursts with few reads drive the FIFO to full and beyond, which separates a correct overrun from one that overwrites or drops stored data. Drain-heavy bursts then expose each head in turn, which shows whether the error bits follow the head character or the most recent arrival. Runs of consecutive break characters, broken by clean ones, check that exactly one break entry is stored per condition. Status reads and data reads placed in the same cycle as arrivals check the precedence of capture and overrun over clear, and show that the summary bit tracks the tagged characters actually still queued.

// File: rtl/uart_lsr_pkg.sv
package uart_lsr_pkg;

  // error tags carried with every stored character; the packing order
  // matches status bits 4:2 (brk, frm, par)
  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } err_tag_t;

  function automatic logic tag_any(input err_tag_t t);
    return t.brk | t.frm | t.par;
  endfunction

  // occupancy counter step: +1, -1 or hold
  function automatic logic [15:0] count_step(input logic [15:0] c,
                                             input logic inc, input logic dec);
    logic [15:0] r;
    r = c;
    if (inc && !dec) r = c + 16'd1;
    else if (dec && !inc) r = c - 16'd1;
    return r;
  endfunction

endpackage

// File: rtl/lsr_break_gate.sv
module lsr_break_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_done,
  input  logic rx_brk,
  output logic load_ok,
  output logic in_break
);
  // a break character arriving while a break is already running is dropped
  assign load_ok = !(rx_done && rx_brk && in_break);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       in_break <= 1'b0;
    else if (rx_done) in_break <= rx_brk;
  end
endmodule

// File: rtl/lsr_rx_fifo.sv
module lsr_rx_fifo
  import uart_lsr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] din,
  input  err_tag_t          din_tag,
  output logic [DATA_W-1:0] head_data,
  output err_tag_t          head_tag,
  output err_tag_t          next_tag,
  output logic [CW-1:0]     count,
  output logic              empty,
  output logic              full,
  output logic              two_plus
);
  logic [DATA_W-1:0] data_mem [DEPTH];
  err_tag_t          tag_mem  [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) begin
      data_mem[wr_ptr] <= din;
      tag_mem[wr_ptr]  <= din_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_inc(wr_ptr);
      if (pop)  rd_ptr <= ptr_inc(rd_ptr);
      count <= CW'(count_step(16'(count), push, pop));
    end
  end

  assign head_data = data_mem[rd_ptr];
  assign head_tag  = tag_mem[rd_ptr];
  assign next_tag  = tag_mem[ptr_inc(rd_ptr)];
  assign empty     = (count == '0);
  assign full      = (count == CW'(DEPTH));
  assign two_plus  = (count > CW'(1));
endmodule

// File: rtl/lsr_status.sv
module lsr_status
  import uart_lsr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     lsr_rd,
  input  logic     ovr_evt,
  input  logic     cap_en,
  input  err_tag_t cap_tag,
  input  logic     push_tagged,
  input  logic     pop_tagged,
  output logic     ovr_flag,
  output err_tag_t head_flags,
  output logic     any_tagged
);
  logic [CW-1:0] tag_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_flag   <= 1'b0;
      head_flags <= '0;
      tag_cnt    <= '0;
    end else begin
      // a new event wins over a clear in the same cycle
      ovr_flag   <= (ovr_flag && !lsr_rd) || ovr_evt;
      head_flags <= (lsr_rd ? err_tag_t'(3'b000) : head_flags)
                    | (cap_en ? cap_tag : err_tag_t'(3'b000));
      tag_cnt    <= CW'(count_step(16'(tag_cnt), push_tagged, pop_tagged));
    end
  end

  assign any_tagged = (tag_cnt != '0);
endmodule

// File: rtl/uart_lsr_core.sv
module uart_lsr_core
  import uart_lsr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_par_err,
  input  logic              rx_frm_err,
  input  logic              rx_brk,
  input  logic              tx_fifo_empty,
  input  logic              tx_shift_empty,
  input  logic              lsr_rd,
  input  logic              rbr_rd,
  output logic [DATA_W-1:0] rbr_data,
  output logic [7:0]        lsr
);
  err_tag_t      in_tag, head_tag, next_tag, head_flags, cap_tag;
  logic          load_ok, in_break;
  logic          fifo_empty, fifo_full, two_plus;
  logic [CW-1:0] fifo_count;
  logic          push_ok, pop_ok, ovr_evt, cap_en;
  logic          ovr_flag, any_tagged;

  assign in_tag = '{brk: rx_brk, frm: rx_frm_err, par: rx_par_err};

  lsr_break_gate u_gate (
    .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_brk(rx_brk),
    .load_ok(load_ok), .in_break(in_break)
  );

  // named internal events
  assign push_ok = rx_done && load_ok && !fifo_full;
  assign ovr_evt = rx_done && load_ok && fifo_full;
  assign pop_ok  = rbr_rd && !fifo_empty;

  // a character becomes head: pop exposing the next entry, or a push
  // landing in an empty FIFO (or in one emptied by this pop)
  assign cap_en  = (pop_ok && (two_plus || push_ok)) || (fifo_empty && push_ok);
  assign cap_tag = (pop_ok && two_plus) ? next_tag : in_tag;

  lsr_rx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push_ok), .pop(pop_ok),
    .din(rx_data), .din_tag(in_tag),
    .head_data(rbr_data), .head_tag(head_tag), .next_tag(next_tag),
    .count(fifo_count), .empty(fifo_empty), .full(fifo_full),
    .two_plus(two_plus)
  );

  lsr_status #(.DEPTH(DEPTH)) u_stat (
    .clk(clk), .rst_n(rst_n), .lsr_rd(lsr_rd), .ovr_evt(ovr_evt),
    .cap_en(cap_en), .cap_tag(cap_tag),
    .push_tagged(push_ok && tag_any(in_tag)),
    .pop_tagged(pop_ok && tag_any(head_tag)),
    .ovr_flag(ovr_flag), .head_flags(head_flags), .any_tagged(any_tagged)
  );

  // R10: all state above resets to empty / clear
  assign lsr = {any_tagged,
                tx_fifo_empty && tx_shift_empty,
                tx_fifo_empty,
                head_flags,
                ovr_flag,
                !fifo_empty};
endmodule

// File: rtl/uart_lsr_checker.sv
module uart_lsr_checker #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lsr_rd,
  input logic          push_ok,
  input logic          pop_ok,
  input logic          ovr_evt,
  input logic          fifo_empty,
  input logic          fifo_full,
  input logic [CW-1:0] fifo_count,
  input logic [7:0]    lsr
);
  // R1
  first_push_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && fifo_empty) |=> lsr[0]);

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CW'(DEPTH));

  // R3
  overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> lsr[1]);

  // R3
  overrun_keeps_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && !pop_ok) |=> fifo_full);

  // R4
  overrun_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !ovr_evt) |=> !lsr[1]);

  // R7
  summary_implies_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lsr[7] |-> lsr[0]);

  // R9
  tx_empty_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lsr[6] |-> lsr[5]);
endmodule

bind uart_lsr_core uart_lsr_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .lsr_rd(lsr_rd), .push_ok(push_ok),
  .pop_ok(pop_ok), .ovr_evt(ovr_evt), .fifo_empty(fifo_empty),
  .fifo_full(fifo_full), .fifo_count(fifo_count), .lsr(lsr)
);

// File: tb/uart_lsr_core_test.sv
`timescale 1ns/1ps
module uart_lsr_core_test;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_done = 0, rx_par_err = 0, rx_frm_err = 0, rx_brk = 0;
  logic [7:0] rx_data = 0;
  logic tx_fifo_empty = 1, tx_shift_empty = 1, lsr_rd = 0, rbr_rd = 0;
  logic [7:0] rbr_data, lsr;

  int checks = 0, fails = 0;

  // bench model: entries packed {brk, frm, par, data}
  logic [10:0] mq[$];
  bit          m_ovr, m_inbrk;
  bit [2:0]    m_flags;

  always #2 clk = ~clk;

  uart_lsr_core uut (
    .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_data(rx_data),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rx_brk(rx_brk),
    .tx_fifo_empty(tx_fifo_empty), .tx_shift_empty(tx_shift_empty),
    .lsr_rd(lsr_rd), .rbr_rd(rbr_rd), .rbr_data(rbr_data), .lsr(lsr)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit model_tagged();
    foreach (mq[i]) if (mq[i][10:8] != 3'b000) return 1'b1;
    return 1'b0;
  endfunction

  // advance the model by one edge using the inputs held in that cycle
  task automatic model_edge();
    int  n = mq.size();
    bit  drop = rx_done && rx_brk && m_inbrk;
    bit  acc  = rx_done && !drop && (n < DEPTH);
    bit  ovr  = rx_done && !drop && (n == DEPTH);
    bit  pop  = rbr_rd && (n > 0);
    logic [10:0] incoming = {rx_brk, rx_frm_err, rx_par_err, rx_data};
    bit [2:0] cap = 3'b000;
    if (pop) begin
      if (n >= 2) cap = mq[1][10:8];
      else if (acc) cap = incoming[10:8];
    end else if (n == 0 && acc) cap = incoming[10:8];
    m_flags = (lsr_rd ? 3'b000 : m_flags) | cap;
    m_ovr   = (m_ovr && !lsr_rd) || ovr;
    if (rx_done) m_inbrk = rx_brk;
    if (pop) void'(mq.pop_front());
    if (acc) mq.push_back(incoming);
  endtask

  task automatic compare();
    check("R1 data ready", {7'd0, lsr[0]}, {7'd0, mq.size() != 0});
    check("R3/R4 overrun", {7'd0, lsr[1]}, {7'd0, m_ovr});
    check("R5 parity/framing", {6'd0, lsr[3:2]}, {6'd0, m_flags[1:0]});
    check("R6 break", {7'd0, lsr[4]}, {7'd0, m_flags[2]});
    check("R8 thr empty", {7'd0, lsr[5]}, {7'd0, tx_fifo_empty});
    check("R9 tx idle", {7'd0, lsr[6]}, {7'd0, tx_fifo_empty && tx_shift_empty});
    check("R7 fifo error summary", {7'd0, lsr[7]}, {7'd0, model_tagged()});
    if (mq.size() != 0) check("R2 head data order", rbr_data, mq[0][7:0]);
  endtask

  // one cycle: drive at a falling edge, step model after the rising edge
  task automatic cyc(input bit d, input logic [7:0] v, input bit pe, input bit fe,
                     input bit bk, input bit rr, input bit lr);
    rx_done = d; rx_data = v; rx_par_err = pe; rx_frm_err = fe; rx_brk = bk;
    rbr_rd = rr; lsr_rd = lr;
    @(posedge clk);
    @(negedge clk);
    model_edge();
    compare();
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 reset value", lsr, 8'h60);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after release", lsr, 8'h60);

    // R1/R3: fill beyond depth, read status, drain in order
    for (int i = 0; i < DEPTH + 2; i++) cyc(1, 8'(8'h30 + i), 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1);
    cyc(1, 8'hEE, 0, 0, 0, 0, 1);  // R4: overrun in the read cycle stays set
    cyc(0, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < DEPTH + 1; i++) cyc(0, 0, 0, 0, 0, 1, 0);

    // R5/R7: tagged chars reach head in turn; read in pop cycles
    cyc(1, 8'h01, 1, 0, 0, 0, 0);
    cyc(1, 8'h02, 0, 1, 0, 0, 0);
    cyc(1, 8'h03, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 1, 1);
    cyc(0, 0, 0, 0, 0, 1, 1);
    cyc(0, 0, 0, 0, 0, 1, 1);

    // R6: one break per condition
    cyc(1, 8'h00, 0, 1, 1, 0, 0);
    cyc(1, 8'h00, 0, 1, 1, 0, 0);
    cyc(1, 8'h00, 0, 1, 1, 0, 0);
    cyc(1, 8'h55, 0, 0, 0, 0, 0);
    cyc(1, 8'h00, 0, 0, 1, 0, 0);
    cyc(1, 8'h00, 0, 0, 1, 0, 0);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 1, 1);

    // random phases: fill-heavy then drain-heavy
    for (int ph = 0; ph < 12; ph++) begin
      int pd = (ph % 2 == 0) ? 80 : 25;
      int pr = (ph % 2 == 0) ? 15 : 70;
      for (int k = 0; k < 250; k++) begin
        tx_fifo_empty  = ($urandom % 3) != 0;
        tx_shift_empty = ($urandom % 2) != 0;
        cyc(($urandom % 100) < pd, 8'($urandom), ($urandom % 8) == 0,
            ($urandom % 8) == 0, ($urandom % 6) == 0,
            ($urandom % 100) < pr, ($urandom % 5) == 0);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule